// File: doc/BRIEF.md
# Receive Loss-of-Signal Alarm Detector

This block raises the loss-of-signal alarm for a dual-rail line receiver. It runs on the recovered clock and samples the retimed positive and negative data rails once per cycle. A sample counts as a received one when either rail is high. A long unbroken stretch of zeros sets a digital alarm. That alarm is released only when the recent traffic again carries enough ones, and never before it has been high for a minimum time.

A second source is a loss flag from an analog peak detector, which arrives asynchronously. The block brings it into the clock domain through two flops and stretches it to a minimum width. The combined alarm is high while either source reports loss. The digital indication is also driven out on its own, so that each path can be observed separately.

Top module: `rx_los_alarm`

## Requirements
- R1: A sampled bit is a one when `rx_pos` or `rx_neg` is high, from either rail alone or both. It is a zero only when both rails are low.
- R2: While `los_digital` is low, it goes high right after the clock edge that samples the SET_RUN-th consecutive zero (default 160).
- R3: Once high, `los_digital` may fall only on an edge where the 32 most recent sampled bits, the current one included, hold at least 8 ones. With only 7 ones in that window it stays high.
- R4: `los_digital` stays high for at least 32 consecutive cycles each time it is set.
- R5: Any one restarts the zero count. SET_RUN-1 zeros, then a one, then SET_RUN-1 more zeros leave `los_digital` low.
- R6: The analog flag `ana_los_raw` passes through two synchronizer flops. A high level that is first sampled at edge N makes `los_alarm` high after edge N+2.
- R7: After it rises, the stretched analog indication stays high for at least 32 cycles and for as long as the synchronized flag stays high. It falls on the first edge where both conditions are over.
- R8: `los_alarm` is high exactly when the digital indication or the stretched analog indication is high.
- R9: After the active-high synchronous reset `rst`, `los_digital` and `los_alarm` are high, the bit window holds no ones, all counters are zero, and the analog path is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_pos | input | 1 | Retimed positive-mark rail |
| rx_neg | input | 1 | Retimed negative-mark rail |
| ana_los_raw | input | 1 | Asynchronous analog loss flag |
| los_alarm | output | 1 | Combined loss-of-signal alarm |
| los_digital | output | 1 | Digital (data-pattern) loss indication only |

## Verification
If the running ones count drifts from the true window content, `los_digital` releases too early or too late. This shows on the first recovery edge after the drift, and at most 32 bits later. A zero-run counter that is stuck or fails to restart moves the set edge by one or more cycles, and per-cycle comparison catches this on the 160th zero. A wrong hold counter in either path shortens or lengthens the alarm pulse. This is visible at the 32-cycle boundary, which the directed cases probe on both sides.

// File: rtl/los_pkg.sv
package los_pkg;
    localparam int unsigned LOS_WIN      = 32;
    localparam int unsigned LOS_ONES_CLR = 8;
    localparam int unsigned LOS_SET_RUN  = 160;
    localparam int unsigned LOS_MIN_HOLD = 32;

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;
endpackage

// File: rtl/los_sync2.sv
module los_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    import los_pkg::*;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign sync_o = q.s2;
endmodule

// File: rtl/los_stretch.sv
module los_stretch #(
    parameter int unsigned MIN_HOLD = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_i,
    output logic flag_o
);
    localparam int unsigned HW = $clog2(MIN_HOLD + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(MIN_HOLD);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          flag;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (!q.flag) begin
            if (flag_i) begin
                d.flag = 1'b1;
                d.cnt  = HW'(1);
            end
        end else begin
            if (q.cnt != HOLD_V) d.cnt = q.cnt + HW'(1);
            if (!flag_i && q.cnt >= HOLD_V) begin
                d.flag = 1'b0;
                d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign flag_o = q.flag;

    assert_ana_follow_R7: assert property (@(posedge clk) disable iff (rst)
        flag_i |=> q.flag);
    assert_ana_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(q.flag) |-> $past(q.cnt) >= HOLD_V);
endmodule

// File: rtl/los_density_det.sv
module los_density_det #(
    parameter int unsigned WIN      = 32,
    parameter int unsigned ONES_CLR = 8,
    parameter int unsigned SET_RUN  = 160,
    parameter int unsigned MIN_HOLD = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    output logic flag_o
);
    localparam int unsigned CW = $clog2(WIN + 1);
    localparam int unsigned ZW = $clog2(SET_RUN + 1);
    localparam int unsigned HW = $clog2(MIN_HOLD + 1);
    localparam logic [CW-1:0] CLR_V  = CW'(ONES_CLR);
    localparam logic [ZW-1:0] RUN_V  = ZW'(SET_RUN);
    localparam logic [HW-1:0] HOLD_V = HW'(MIN_HOLD);

    typedef struct packed {
        logic [WIN-1:0] win;
        logic [CW-1:0]  ones;
        logic [ZW-1:0]  zrun;
        logic [HW-1:0]  hold;
        logic           flag;
    } st_t;

    st_t q, d;
    logic [CW-1:0] add_v, sub_v;

    always_comb begin
        add_v  = {{(CW-1){1'b0}}, bit_i};
        sub_v  = {{(CW-1){1'b0}}, q.win[WIN-1]};
        d      = q;
        d.win  = {q.win[WIN-2:0], bit_i};
        d.ones = q.ones + add_v - sub_v;
        if (bit_i)             d.zrun = '0;
        else if (q.zrun != RUN_V) d.zrun = q.zrun + ZW'(1);
        if (q.flag) begin
            if (q.hold != HOLD_V) d.hold = q.hold + HW'(1);
            if (q.hold >= HOLD_V && d.ones >= CLR_V) begin
                d.flag = 1'b0;
                d.hold = '0;
            end
        end else if (d.zrun == RUN_V) begin
            d.flag = 1'b1;
            d.hold = HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.flag <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign flag_o = q.flag;

    assert_count_exact_R3: assert property (@(posedge clk) disable iff (rst)
        q.ones == CW'($countones(q.win)));
    assert_clear_density_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(q.flag) |-> q.ones >= CLR_V);
    assert_min_width_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(q.flag) |-> $past(q.hold) >= HOLD_V);
    assert_set_on_run_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(q.flag) |-> q.zrun == RUN_V && q.win[0] == 1'b0);
endmodule

// File: rtl/rx_los_alarm.sv
module rx_los_alarm #(
    parameter int unsigned WIN      = los_pkg::LOS_WIN,
    parameter int unsigned ONES_CLR = los_pkg::LOS_ONES_CLR,
    parameter int unsigned SET_RUN  = los_pkg::LOS_SET_RUN,
    parameter int unsigned MIN_HOLD = los_pkg::LOS_MIN_HOLD
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic ana_los_raw,
    output logic los_alarm,
    output logic los_digital
);
    logic mark_w, ana_sync_w, ana_str_w, dig_w;

    assign mark_w = rx_pos | rx_neg;

    los_density_det #(
        .WIN(WIN), .ONES_CLR(ONES_CLR), .SET_RUN(SET_RUN), .MIN_HOLD(MIN_HOLD)
    ) u_dig (
        .clk(clk), .rst(rst), .bit_i(mark_w), .flag_o(dig_w)
    );

    los_sync2 u_sync (
        .clk(clk), .rst(rst), .async_i(ana_los_raw), .sync_o(ana_sync_w)
    );

    los_stretch #(.MIN_HOLD(MIN_HOLD)) u_str (
        .clk(clk), .rst(rst), .flag_i(ana_sync_w), .flag_o(ana_str_w)
    );

    assign los_digital = dig_w;
    assign los_alarm   = dig_w | ana_str_w;

    assert_alarm_covers_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ana_sync_w) |=> los_alarm);
endmodule

// File: tb/sim_rx_los_alarm.sv
module sim_rx_los_alarm;
    logic clk = 1'b0;
    logic rst, rx_pos, rx_neg, ana_los_raw;
    logic los_alarm, los_digital;
    int total = 0;
    int bad = 0;

    // reference model state
    bit [31:0] m_win;
    int m_zrun, m_dhold, m_acnt;
    bit m_dflag, m_s1, m_s2, m_aflag;

    always #2 clk = ~clk;

    rx_los_alarm u0 (
        .clk(clk), .rst(rst), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .ana_los_raw(ana_los_raw), .los_alarm(los_alarm), .los_digital(los_digital)
    );

    function automatic int ones_of(bit [31:0] w);
        int n = 0;
        for (int i = 0; i < 32; i++) n += w[i];
        return n;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit b, s2_old;
        if (rst) begin
            m_win = '0; m_zrun = 0; m_dhold = 0; m_dflag = 1;
            m_s1 = 0; m_s2 = 0; m_aflag = 0; m_acnt = 0;
            return;
        end
        b = rx_pos | rx_neg;
        m_win = {m_win[30:0], b};
        if (b) m_zrun = 0; else if (m_zrun < 160) m_zrun++;
        if (m_dflag) begin
            if (m_dhold >= 32 && ones_of(m_win) >= 8) begin m_dflag = 0; m_dhold = 0; end
            else if (m_dhold < 32) m_dhold++;
        end else if (m_zrun == 160) begin m_dflag = 1; m_dhold = 1; end
        s2_old = m_s2;
        m_s2 = m_s1;
        m_s1 = ana_los_raw;
        if (!m_aflag) begin
            if (s2_old) begin m_aflag = 1; m_acnt = 1; end
        end else if (!s2_old && m_acnt >= 32) begin m_aflag = 0; m_acnt = 0; end
        else if (m_acnt < 32) m_acnt++;
    endtask

    // one cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(bit p, bit n, bit a, string tag);
        rx_pos = p; rx_neg = n; ana_los_raw = a;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " digital R2"}, los_digital, m_dflag);
        chk({tag, " alarm R8"}, los_alarm, m_dflag | m_aflag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; rx_pos = 0; rx_neg = 0; ana_los_raw = 0;
        @(negedge clk);
        repeat (3) cyc(0, 0, 0, "reset");
        chk("R9 reset digital", los_digital, 1'b1);
        chk("R9 reset alarm", los_alarm, 1'b1);
        rst = 0;

        // R4 after reset: hold limits release even with full density
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, "R4");
        chk("R4 held after 20 ones", los_digital, 1'b1);
        for (int i = 0; i < 20; i++) cyc(1, 1, 0, "R3");
        chk("R3 released by density", los_digital, 1'b0);
        chk("R9 analog idle", los_alarm, 1'b0);

        // R5 zero run restarted by a negative-rail mark (R1)
        for (int i = 0; i < 159; i++) cyc(0, 0, 0, "R5");
        chk("R5 159 zeros", los_digital, 1'b0);
        cyc(0, 1, 0, "R1");
        for (int i = 0; i < 159; i++) cyc(0, 0, 0, "R5");
        chk("R5 run restarted by negative rail R1", los_digital, 1'b0);
        cyc(0, 0, 0, "R2");
        chk("R2 set on 160th zero", los_digital, 1'b1);

        // R3: 7 ones in window do not clear, 8th does
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, "R3");
        for (int i = 0; i < 7; i++) cyc(0, 1, 0, "R3");
        chk("R3 seven ones keep alarm", los_digital, 1'b1);
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, "R3");
        chk("R3 still high", los_digital, 1'b1);
        for (int i = 0; i < 30; i++) cyc(0, 0, 0, "R3");
        for (int i = 0; i < 7; i++) cyc(1, 0, 0, "R3");
        chk("R3 seven again", los_digital, 1'b1);
        cyc(1, 0, 0, "R3");
        chk("R3 eighth one clears", los_digital, 1'b0);

        // R4: release right after a set is blocked until 32 cycles high
        for (int i = 0; i < 160; i++) cyc(0, 0, 0, "R2");
        chk("R2 set again", los_digital, 1'b1);
        for (int i = 0; i < 31; i++) cyc(1, 0, 0, "R4");
        chk("R4 held at 31", los_digital, 1'b1);
        cyc(1, 0, 0, "R4");
        chk("R4 released at 32", los_digital, 1'b0);

        // R6/R7: one-cycle analog pulse
        cyc(1, 0, 1, "R6");
        chk("R6 after 1 edge", los_alarm, 1'b0);
        cyc(1, 0, 0, "R6");
        chk("R6 after 2 edges", los_alarm, 1'b0);
        cyc(1, 0, 0, "R6");
        chk("R6 after 3 edges", los_alarm, 1'b1);
        for (int i = 0; i < 31; i++) cyc(1, 0, 0, "R7");
        chk("R7 held 32 cycles", los_alarm, 1'b1);
        chk("R8 digital quiet", los_digital, 1'b0);
        cyc(1, 0, 0, "R7");
        chk("R7 dropped after 32", los_alarm, 1'b0);

        // R7: long analog level
        for (int i = 0; i < 50; i++) cyc(1, 0, 1, "R7");
        cyc(1, 0, 0, "R7");
        cyc(1, 0, 0, "R7");
        chk("R7 follows long level", los_alarm, 1'b1);
        cyc(1, 0, 0, "R7");
        chk("R7 drops after level", los_alarm, 1'b0);

        // random regimes: dense, sparse, silent, with rare analog pulses
        for (int blk = 0; blk < 30; blk++) begin
            int dens = $urandom_range(0, 3);
            int len = $urandom_range(40, 220);
            for (int i = 0; i < len; i++) begin
                int r = $urandom_range(0, 99);
                bit mk = (dens == 0) ? 1'b0 : (dens == 1) ? (r < 4) :
                         (dens == 2) ? (r < 25) : (r < 70);
                bit side = $urandom_range(0, 1);
                bit an = ($urandom_range(0, 199) == 0);
                cyc(mk & side, mk & ~side, an, "R8 random");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule